// File: doc/BRIEF.md
# UART Receive FIFO with Control and Status

This block is the receive queue of one UART channel. A receiver front end offers one byte per cycle on a valid strobe, and the block stores it in a byte-wide FIFO whose depth is a parameter (default 16). A register-read port pops the oldest byte. A 16-bit control word written by software enables the FIFO, flushes the receive queue or requests a transmit flush, and holds 3-bit trigger codes for both directions. The block turns those codes into trigger thresholds by scaling them with a multiplier that depends on the channel number.

A packed 32-bit status word reports the receive occupancy, a receive-full flag, and the transmit occupancy supplied by the neighbouring transmit queue, with its own full flag. The block raises a one-cycle error pulse toward the interrupt unit when a byte is lost because the queue is full, or when a read hits an empty queue. A DMA busy line stays high while receive DMA is selected and nothing is waiting.

With the FIFO disabled, a single holding register takes the place of the queue and carries its own data-ready flag.

Top module: `uart_rxq`

## Requirements
- R1: After synchronous reset the control readback is 0, the status word is 0, `data_ready` and `err_pulse` are 0, the receive threshold shows code 1 scaled by the channel multiplier and the transmit threshold is 0.
- R2: A control write stores the word in the clock edge that ends it. Readback bit 0 is the enable, bits [6:4] are the receive code and bits [10:8] are the transmit code. The flush bits 1 and 2 always read back as 0 after the write.
- R3: The receive threshold is (bits[6:4] + 1) × M and the transmit threshold is bits[10:8] × M. M is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel. Both thresholds are 9 bits wide.
- R4: With the FIFO enabled, bytes come out of `rd_data` in arrival order. `rd_data` shows the oldest byte before the read edge. Status bits [7:0] hold the number of stored bytes, and `data_ready` is 1 exactly when that number is nonzero.
- R5: When the FIFO holds DEPTH bytes, status bits [7:0] read 0 and status bit 8 reads 1. At every other level bit 8 is 0.
- R6: A byte offered while the FIFO is full, with no read in the same cycle, is dropped, and `err_pulse` is 1 for the following cycle. A read in that same cycle makes room, so the byte is accepted and no error is raised.
- R7: A read while the FIFO is enabled and empty shows `rd_data` = 0 and makes `err_pulse` 1 for the following cycle.
- R8: A control write with bit 1 set empties the receive FIFO at that edge, so the count is 0 in the next cycle. Any byte or read offered in the same cycle is discarded. `tx_flush` is 1 during any control write with bit 2 set.
- R9: `dma_busy` is 1 when `dma_mode` equals 2 and the receive FIFO is empty, and 0 otherwise.
- R10: With bit 0 clear, an offered byte goes to a holding register and sets `data_ready`, and `rd_data` shows that register. A read clears `data_ready` at the next edge. The FIFO contents and count are not touched.
- R11: Status bits [23:16] carry `tx_level`, and status bit 24 is 1 when `tx_level` is DEPTH or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| dma_mode | input | 2 | Receive mode select from the channel control; 2 selects DMA |
| rx_valid | input | 1 | Byte offered by the receiver front end |
| rx_byte | input | 8 | Byte from the receiver front end |
| rd_en | input | 1 | Data register read (pop) |
| tx_level | input | 8 | Occupancy of the transmit queue |
| ctrl_rd | output | 16 | Control word readback |
| status | output | 32 | Packed status word |
| rx_thresh | output | 9 | Receive trigger threshold |
| tx_thresh | output | 9 | Transmit trigger threshold |
| rd_data | output | 8 | Read data |
| data_ready | output | 1 | Receive data available |
| dma_busy | output | 1 | Receive DMA busy |
| err_pulse | output | 1 | One-cycle overflow or underflow indication |
| tx_flush | output | 1 | Transmit queue flush request |

## Verification
The hardest case to reach is a full queue that is offered a byte in the same cycle as a read. That case must accept the byte without an error, while the same offer without the read must drop the byte and pulse the error. Directed steps first fill the queue to DEPTH and push one byte too many, then drain it. After that, a long seeded random phase biased toward writes keeps the queue pinned near full, so push-with-pop and push-without-pop at full occur many times. Each of those cycles is compared against a queue model. The thresholds are checked on three channel numbers at once, with copies of the block sharing the same inputs.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef struct packed {
        logic [4:0] rsv_hi;
        logic [2:0] tx_code;
        logic       rsv_b7;
        logic [2:0] rx_code;
        logic       rsv_b3;
        logic       tx_flush;
        logic       rx_flush;
        logic       enable;
    } ctrl_t;

    localparam int THR_W = 9;
    localparam logic [1:0] MODE_DMA = 2'd2;

    function automatic int chan_mult(input int ch);
        case (ch)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [THR_W-1:0] scale_code(input logic [3:0] code, input int ch);
        return THR_W'(32'(code) * chan_mult(ch));
    endfunction

endpackage

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
    import uart_rxq_pkg::*;
#(
    parameter int CHANNEL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_wdata,
    output ctrl_t            ctrl,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic [THR_W-1:0] rx_thresh,
    output logic [THR_W-1:0] tx_thresh
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cfg_we) begin
            ctrl_q          <= ctrl_t'(cfg_wdata);
            ctrl_q.rx_flush <= 1'b0;
            ctrl_q.tx_flush <= 1'b0;
        end
    end

    // flushes act on the write edge itself
    assign rx_flush  = cfg_we & cfg_wdata[1];
    assign tx_flush  = cfg_we & cfg_wdata[2];
    assign ctrl      = ctrl_q;
    assign rx_thresh = scale_code({1'b0, ctrl_q.rx_code} + 4'd1, CHANNEL);
    assign tx_thresh = scale_code({1'b0, ctrl_q.tx_code}, CHANNEL);

    // R2: flush bits never stay set in the stored word
    a_r2_self_clear: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (!ctrl_q.rx_flush && !ctrl_q.tx_flush));

endmodule

// File: rtl/uart_rxq_fifo.sv
module uart_rxq_fifo #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [AW:0]   wptr, rptr;
    logic [7:0]    mem [DEPTH];
    logic          do_push, do_pop;
    logic [AW-1:0] w_idx, r_idx;

    assign w_idx = wptr[AW-1:0];
    assign r_idx = rptr[AW-1:0];

    function automatic logic [AW:0] bump(input logic [AW:0] p);
        if (p[AW-1:0] == AW'(DEPTH - 1))
            return {~p[AW], {AW{1'b0}}};
        return p + 1'b1;
    endfunction

    always_comb begin
        if (wptr[AW] == rptr[AW])
            count = CW'(w_idx) - CW'(r_idx);
        else
            count = CW'(DEPTH) - CW'(r_idx) + CW'(w_idx);
    end

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop & ~empty & ~flush;
    assign do_push = push & (~full | do_pop) & ~flush;
    assign dout    = mem[r_idx];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[w_idx] <= din;
    end

    // R4: occupancy never exceeds the depth
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R8: a flush leaves the queue empty
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

    // R6: a full queue pushed without a pop stays full, nothing overwritten
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (full && $stable(rptr)));

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int CHANNEL = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    input  logic [1:0]  dma_mode,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rd_en,
    input  logic [7:0]  tx_level,
    output logic [15:0] ctrl_rd,
    output logic [31:0] status,
    output logic [8:0]  rx_thresh,
    output logic [8:0]  tx_thresh,
    output logic [7:0]  rd_data,
    output logic        data_ready,
    output logic        dma_busy,
    output logic        err_pulse,
    output logic        tx_flush
);

    localparam int CW = $clog2(DEPTH + 1);

    ctrl_t         ctrl;
    logic          rx_flush, en;
    logic [7:0]    f_dout;
    logic [CW-1:0] f_count;
    logic          f_full, f_empty;
    logic          ovf, udf;
    logic [7:0]    hold_q;
    logic          hold_vld;

    uart_rxq_ctrl #(.CHANNEL(CHANNEL)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush),
        .rx_thresh (rx_thresh),
        .tx_thresh (tx_thresh)
    );

    assign en = ctrl.enable;

    uart_rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush),
        .push  (en & rx_valid),
        .pop   (en & rd_en),
        .din   (rx_byte),
        .dout  (f_dout),
        .count (f_count),
        .full  (f_full),
        .empty (f_empty)
    );

    // error sources toward the interrupt unit
    assign ovf = en & rx_valid & f_full & ~rd_en;
    assign udf = en & rd_en & f_empty;

    always_ff @(posedge clk) begin
        if (rst) err_pulse <= 1'b0;
        else     err_pulse <= (ovf | udf) & ~rx_flush;
    end

    // holding register used while the queue is disabled
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            hold_vld <= 1'b0;
        end else if (!en) begin
            if (rx_valid) begin
                hold_q   <= rx_byte;
                hold_vld <= 1'b1;
            end else if (rd_en) begin
                hold_vld <= 1'b0;
            end
        end
    end

    assign rd_data    = en ? (f_empty ? 8'h00 : f_dout) : hold_q;
    assign data_ready = en ? ~f_empty : hold_vld;
    assign dma_busy   = (dma_mode == MODE_DMA) & f_empty;
    assign ctrl_rd    = 16'(ctrl);
    assign status     = {7'b0, (32'(tx_level) >= DEPTH), tx_level,
                         7'b0, f_full, (f_full ? 8'h00 : 8'(f_count))};

    // R6: a dropped byte is reported one cycle later
    a_r6_ovf_err: assert property (@(posedge clk) disable iff (rst)
        (en && rx_valid && f_full && !rd_en && !rx_flush) |=> err_pulse);

    // R7: an empty read is reported one cycle later
    a_r7_udf_err: assert property (@(posedge clk) disable iff (rst)
        (en && rd_en && f_empty && !rx_flush) |=> err_pulse);

    // R10: disabled traffic leaves the queue occupancy alone
    a_r10_fifo_untouched: assert property (@(posedge clk) disable iff (rst)
        (!en && !rx_flush) |=> $stable(f_count));

endmodule

// File: tb/uart_rxq_tb.sv
`timescale 1ns/1ps
module uart_rxq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  dma_mode = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  tx_level = '0;
    logic [15:0] ctrl_rd;
    logic [31:0] status;
    logic [8:0]  rx_thresh, tx_thresh;
    logic [7:0]  rd_data;
    logic        data_ready, dma_busy, err_pulse, tx_flush;

    logic [15:0] x_ctrl [2];
    logic [31:0] x_stat [2];
    logic [8:0]  x_rxt  [2];
    logic [8:0]  x_txt  [2];
    logic [7:0]  x_rd   [2];
    logic        x_dr [2], x_db [2], x_er [2], x_tf [2];

    int pass_n = 0;
    int fail_n = 0;
    bit done = 1'b0;
    byte unsigned q[$];

    always #2.5 clk = ~clk;

    uart_rxq u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dma_mode(dma_mode), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_en(rd_en), .tx_level(tx_level), .ctrl_rd(ctrl_rd), .status(status),
        .rx_thresh(rx_thresh), .tx_thresh(tx_thresh), .rd_data(rd_data),
        .data_ready(data_ready), .dma_busy(dma_busy), .err_pulse(err_pulse),
        .tx_flush(tx_flush)
    );

    uart_rxq #(.CHANNEL(4)) u_dut_c4 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dma_mode(dma_mode), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_en(rd_en), .tx_level(tx_level), .ctrl_rd(x_ctrl[0]), .status(x_stat[0]),
        .rx_thresh(x_rxt[0]), .tx_thresh(x_txt[0]), .rd_data(x_rd[0]),
        .data_ready(x_dr[0]), .dma_busy(x_db[0]), .err_pulse(x_er[0]),
        .tx_flush(x_tf[0])
    );

    uart_rxq #(.CHANNEL(9)) u_dut_c9 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dma_mode(dma_mode), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_en(rd_en), .tx_level(tx_level), .ctrl_rd(x_ctrl[1]), .status(x_stat[1]),
        .rx_thresh(x_rxt[1]), .tx_thresh(x_txt[1]), .rd_data(x_rd[1]),
        .data_ready(x_dr[1]), .dma_busy(x_db[1]), .err_pulse(x_er[1]),
        .tx_flush(x_tf[1])
    );

    function automatic int mult(input int ch);
        if (ch == 0) return 32;
        if (ch == 1 || ch == 4) return 8;
        if (ch == 2 || ch == 3) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] exp_rx_stat(input int n);
        return (n == 16) ? 32'h100 : 32'(n);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        if (act === exp) pass_n++;
        else begin
            fail_n++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfgw(input logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic popchk(input string tag, input logic [7:0] exp);
        rd_en = 1'b1;
        #1 chk(tag, 32'(rd_data), 32'(exp));
        tick();
        rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fail_n++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        @(negedge clk);
        tick(); tick(); tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 ctrl", 32'(ctrl_rd), 0);
        chk("R1 status", status, 0);
        chk("R1 ready", 32'(data_ready), 0);
        chk("R1 err", 32'(err_pulse), 0);
        chk("R1 rx_thresh", 32'(rx_thresh), 32);
        chk("R1 tx_thresh", 32'(tx_thresh), 0);

        // R2 / R3 control and thresholds
        cfgw(16'h0651);
        chk("R2 ctrl", 32'(ctrl_rd), 32'h0651);
        chk("R3 c0 rx", 32'(rx_thresh), 32'(6 * mult(0)));
        chk("R3 c0 tx", 32'(tx_thresh), 32'(6 * mult(0)));
        chk("R3 c4 rx", 32'(x_rxt[0]), 32'(6 * mult(4)));
        chk("R3 c4 tx", 32'(x_txt[0]), 32'(6 * mult(4)));
        chk("R3 c9 rx", 32'(x_rxt[1]), 0);
        cfgw(16'h0771);
        chk("R3 c0 rx max", 32'(rx_thresh), 256);
        chk("R3 c0 tx max", 32'(tx_thresh), 224);
        chk("R3 c4 rx max", 32'(x_rxt[0]), 64);

        // R8 tx flush pulse, R2 self clear
        cfg_we = 1'b1; cfg_wdata = 16'h0777;
        #1 chk("R8 tx_flush", 32'(tx_flush), 1);
        tick();
        cfg_we = 1'b0;
        chk("R2 self clear", 32'(ctrl_rd), 32'h0771);
        #1 chk("R8 tx_flush low", 32'(tx_flush), 0);

        // R9 DMA busy
        dma_mode = 2'd2;
        #1 chk("R9 busy empty", 32'(dma_busy), 1);
        push(8'hA5);
        chk("R9 busy data", 32'(dma_busy), 0);
        chk("R4 ready", 32'(data_ready), 1);
        dma_mode = 2'd1;
        #1 chk("R9 other mode", 32'(dma_busy), 0);
        dma_mode = 2'd2;
        popchk("R4 single", 8'hA5);
        chk("R9 busy again", 32'(dma_busy), 1);
        chk("R4 ready low", 32'(data_ready), 0);

        // R5 full, R6 overflow
        for (int i = 0; i < 16; i++) push(8'(i * 7 + 3));
        chk("R5 full status", status, 32'h100);
        push(8'hEE);
        chk("R6 err", 32'(err_pulse), 1);
        chk("R6 still full", status, 32'h100);
        tick();
        chk("R6 err one cycle", 32'(err_pulse), 0);
        for (int i = 0; i < 16; i++) begin
            popchk("R4 order", 8'(i * 7 + 3));
            chk("R6 no stray err", 32'(err_pulse), 0);
        end
        chk("R4 drained", status, 0);

        // R7 underflow
        popchk("R7 data zero", 8'h00);
        chk("R7 err", 32'(err_pulse), 1);

        // random traffic against a model, biased to keep the queue near full
        dma_mode = 2'd0;
        for (int c = 0; c < 3000; c++) begin
            bit p, r, e;
            logic [7:0] b;
            p = ($urandom % 4) != 0;
            r = ($urandom % 3) == 0;
            b = 8'($urandom);
            rx_valid = p; rx_byte = b; rd_en = r;
            #1;
            chk("R4 rand count", status, exp_rx_stat(q.size()));
            if (r) chk("R4 rand data", 32'(rd_data), (q.size() != 0) ? 32'(q[0]) : 0);
            e = (p && q.size() == 16 && !r) || (r && q.size() == 0);
            if (r && q.size() != 0) void'(q.pop_front());
            if (p && q.size() < 16 && !(e && !r)) q.push_back(b);
            tick();
            chk("R6 R7 rand err", 32'(err_pulse), 32'(e));
        end
        rx_valid = 1'b0; rd_en = 1'b0;
        q.delete();

        // R8 rx flush
        cfgw(16'h0773);
        chk("R8 flushed", status, 0);
        chk("R8 ctrl", 32'(ctrl_rd), 32'h0771);

        // R10 disabled holding register
        push(8'h11); push(8'h22);
        cfgw(16'h0770);
        push(8'h3C);
        chk("R10 ready", 32'(data_ready), 1);
        #1 chk("R10 data", 32'(rd_data), 32'h3C);
        chk("R10 fifo kept", status, 2);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk("R10 ready cleared", 32'(data_ready), 0);
        chk("R10 fifo kept after read", status, 2);
        chk("R10 no err", 32'(err_pulse), 0);

        // R11 transmit fields
        tx_level = 8'd5;
        #1 chk("R11 tx count", status, 32'h0005_0002);
        tx_level = 8'd16;
        #1 chk("R11 tx full", status, 32'h0110_0002);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule